// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital sequencer for a successive-approximation analog-to-digital converter. Software programs it through a small byte-wide register file. It selects an input channel, a conversion-clock ratio and an acquisition length, then sets a start/busy bit. The controller holds the sample switch closed for the chosen acquisition time. It then presents trial codes to an external DAC and reads back an external comparator, settling one result bit per conversion-clock tick from the most significant bit down.

When the last bit is settled, the 10-bit code is written right-justified into a high/low result pair. In the same clock edge the start/busy bit drops and a sticky interrupt flag is raised.

A device reset clears every control field and aborts any activity. It does not disturb the result pair. Software can also abandon an acquisition or conversion at any time by clearing the start bit or the enable bit.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the control register (address 0), the timing register (address 1) and the flag register (address 4) read 0, `irq_o` and `sample_o` are 0, and `dac_code_o` is 0.
- R2: A write to address 0 whose bit 0 (enable) and bit 1 (start) are both 1 starts an operation when none is running. Bit 1 of address 0 reads 1 from the next cycle until the operation ends. Bits 5:2 of that write select the channel, which drives `chan_o`.
- R3: A write to address 0 with bit 1 set but bit 0 clear starts nothing. The busy bit stays 0 and the flag stays 0.
- R4: The result equals the largest code whose trial the comparator accepts. Trial codes are the bits already kept plus the bit under test, tested from bit 9 down to bit 0. `comp_hi_i` = 1 keeps the bit.
- R5: Timing register bits 5:3 select the acquisition length: 0, 2, 4, 6, 8, 12, 16 or 20 conversion-clock periods for codes 0 to 7. `sample_o` is high during acquisition.
- R6: Timing register bits 2:0 select a conversion-clock period of 2, 4, 8, 16, 32 or 64 system clocks for codes 0 to 5. Codes 6 and 7 also give 64.
- R7: A conversion occupies exactly (acquisition periods + 10) × ratio cycles from the start-write edge to the completion edge.
- R8: The result is right-justified. Address 2 bits 1:0 hold result bits 9:8 and its other bits read 0. Address 3 holds result bits 7:0.
- R9: On the completion edge the result pair is loaded, the busy bit clears and the flag (address 4 bit 0, also `irq_o`) sets, all together.
- R10: The flag stays set until software writes address 4 with bit 0 = 0. Writing bit 0 = 1 has no effect on it.
- R11: Writing address 0 with start or enable clear during acquisition or conversion aborts the operation. The result pair and the flag are left unchanged.
- R12: Asserting reset during an operation aborts it and clears the control fields and flag. The result pair keeps its prior value.
- R13: When completion and a flag-clear write fall on the same edge, the flag ends set. When completion and an abort write coincide, the completion stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| comp_hi_i | input | 1 | Comparator: sampled input is at or above the trial code |
| dac_code_o | output | 10 | Trial code for the DAC, 0 outside conversion |
| sample_o | output | 1 | Sample switch closed (acquisition phase) |
| chan_o | output | 4 | Selected analog channel |
| irq_o | output | 1 | Sticky conversion-complete flag |

## Verification
The completion edge can coincide with a software write. That write may clear the flag, or it may clear the start bit to abort. The bench counts cycles from the start write using the known latency. It places each of these writes on the exact completion edge. It then judges the outcome at the ports: the flag must read set, and the result pair must hold the new code. A design that lets the clear or the abort win shows a zero flag or a stale result.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  localparam int SEL_W        = 3;
  localparam int ADDR_W       = 3;
  localparam int ACQ_CNT_W    = 5;
  localparam int MAX_DIV_LOG2 = 6;
  localparam int DIV_CNT_W    = MAX_DIV_LOG2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_TIME = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RHI  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_RLO  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd4;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACQ  = 2'd1,
    SEQ_CONV = 2'd2
  } seq_state_e;

  // Acquisition length in conversion-clock periods: 0,2,4,6,8,12,16,20
  function automatic logic [ACQ_CNT_W-1:0] acq_periods(input logic [SEL_W-1:0] sel);
    logic [ACQ_CNT_W-1:0] s;
    s = ACQ_CNT_W'(sel);
    if (sel < 3'd5) acq_periods = s << 1;
    else            acq_periods = 5'd12 + ((s - 5'd5) << 2);
  endfunction

  // System clocks per conversion-clock period: 2 << min(sel,5)
  function automatic logic [DIV_CNT_W:0] div_ratio(input logic [SEL_W-1:0] sel);
    logic [SEL_W-1:0] e;
    e = (sel > 3'd5) ? 3'd5 : sel;
    div_ratio = (DIV_CNT_W + 1)'(2) << e;
  endfunction

endpackage

// File: rtl/sar_adc_rstsync.sv
module sar_adc_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/sar_adc_clkdiv.sv
module sar_adc_clkdiv
  import sar_adc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  logic [DIV_CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_CNT_W:0]   last_cnt;

  assign last_cnt = div_ratio(div_sel) - 1'b1;
  assign tick     = run && ({1'b0, cnt_q} >= last_cnt);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             abort,
  input  logic [SEL_W-1:0] acq_sel,
  input  logic             comp_hi,
  output logic             busy,
  output logic             sampling,
  output logic [RES_W-1:0] dac_code,
  output logic             done,
  output logic [RES_W-1:0] final_code
);
  localparam int IDX_W = $clog2(RES_W);

  seq_state_e           state_q, state_d;
  logic [ACQ_CNT_W-1:0] acq_q, acq_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [RES_W-1:0]     code_q, code_d;
  logic [RES_W-1:0]     trial_bit;

  assign trial_bit = RES_W'(1) << idx_q;

  always_comb begin
    state_d = state_q;
    acq_d   = acq_q;
    idx_d   = idx_q;
    code_d  = code_q;
    done    = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          code_d  = '0;
          idx_d   = IDX_W'(RES_W - 1);
          acq_d   = acq_periods(acq_sel);
          state_d = (acq_d == '0) ? SEQ_CONV : SEQ_ACQ;
        end
      end
      SEQ_ACQ: begin
        if (abort) begin
          state_d = SEQ_IDLE;
        end else if (tick) begin
          acq_d = acq_q - 1'b1;
          if (acq_q == ACQ_CNT_W'(1)) state_d = SEQ_CONV;
        end
      end
      SEQ_CONV: begin
        if (tick && comp_hi) code_d = code_q | trial_bit;
        if (tick && idx_q == '0) begin
          done    = 1'b1;
          state_d = SEQ_IDLE;
        end else if (abort) begin
          state_d = SEQ_IDLE;
        end else if (tick) begin
          idx_d = idx_q - 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      acq_q   <= '0;
      idx_q   <= '0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      acq_q   <= acq_d;
      idx_q   <= idx_d;
      code_q  <= code_d;
    end
  end

  assign busy       = (state_q != SEQ_IDLE);
  assign sampling   = (state_q == SEQ_ACQ);
  assign dac_code   = (state_q == SEQ_CONV) ? (code_q | trial_bit) : '0;
  assign final_code = code_d;
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
  import sar_adc_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              busy,
  input  logic              done,
  input  logic [RES_W-1:0]  final_code,
  output logic              start,
  output logic              abort,
  output logic              en,
  output logic [CH_W-1:0]   chan,
  output logic [SEL_W-1:0]  div_sel,
  output logic [SEL_W-1:0]  acq_sel,
  output logic              flag,
  output logic [RES_W-1:0]  result
);
  localparam int HI_W = RES_W - DATA_W;

  logic              en_q, en_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic [SEL_W-1:0]  div_q, div_d, acqs_q, acqs_d;
  logic              flag_q, flag_d;
  logic [RES_W-1:0]  res_q;
  logic              wr_ctrl, wr_time, wr_flag, go_bits;
  logic              unused_wr;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_time = wr_en && (wr_addr == ADDR_TIME);
  assign wr_flag = wr_en && (wr_addr == ADDR_FLAG);
  assign go_bits = wr_data[0] && wr_data[1];

  assign start = wr_ctrl && go_bits && !busy;
  assign abort = wr_ctrl && busy && !go_bits;

  always_comb begin
    en_d   = en_q;
    chan_d = chan_q;
    div_d  = div_q;
    acqs_d = acqs_q;
    flag_d = flag_q;
    if (wr_ctrl) begin
      en_d   = wr_data[0];
      chan_d = wr_data[CH_W+1:2];
    end
    if (wr_time) begin
      div_d  = wr_data[SEL_W-1:0];
      acqs_d = wr_data[2*SEL_W-1:SEL_W];
    end
    if (done)                      flag_d = 1'b1;
    else if (wr_flag && !wr_data[0]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      chan_q <= '0;
      div_q  <= '0;
      acqs_q <= '0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      chan_q <= chan_d;
      div_q  <= div_d;
      acqs_q <= acqs_d;
      flag_q <= flag_d;
    end
  end

  // Result pair survives ordinary resets: loaded only on completion
  always_ff @(posedge clk) begin
    if (done) res_q <= final_code;
  end

  always_comb begin
    case (rd_addr)
      ADDR_CTRL: rd_data = DATA_W'({chan_q, busy, en_q});
      ADDR_TIME: rd_data = DATA_W'({acqs_q, div_q});
      ADDR_RHI:  rd_data = DATA_W'(res_q[RES_W-1:RES_W-HI_W]);
      ADDR_RLO:  rd_data = res_q[DATA_W-1:0];
      ADDR_FLAG: rd_data = DATA_W'(flag_q);
      default:   rd_data = '0;
    endcase
  end

  assign unused_wr = ^wr_data[DATA_W-1:CH_W+2];

  assign en      = en_q;
  assign chan    = chan_q;
  assign div_sel = div_q;
  assign acq_sel = acqs_q;
  assign flag    = flag_q;
  assign result  = res_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              comp_hi_i,
  output logic [RES_W-1:0]  dac_code_o,
  output logic              sample_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              irq_o
);
  logic             rst_sync_n;
  logic             tick, seq_busy, seq_done, start_req, abort_req, ctrl_en;
  logic [SEL_W-1:0] div_sel, acq_sel;
  logic [RES_W-1:0] final_code, res_val;

  sar_adc_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sar_adc_clkdiv u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (seq_busy),
    .restart (start_req),
    .div_sel (div_sel),
    .tick    (tick)
  );

  sar_adc_seq #(.RES_W(RES_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick       (tick),
    .start      (start_req),
    .abort      (abort_req),
    .acq_sel    (acq_sel),
    .comp_hi    (comp_hi_i),
    .busy       (seq_busy),
    .sampling   (sample_o),
    .dac_code   (dac_code_o),
    .done       (seq_done),
    .final_code (final_code)
  );

  sar_adc_regs #(.RES_W(RES_W), .DATA_W(DATA_W), .CH_W(CH_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .busy       (seq_busy),
    .done       (seq_done),
    .final_code (final_code),
    .start      (start_req),
    .abort      (abort_req),
    .en         (ctrl_en),
    .chan       (chan_o),
    .div_sel    (div_sel),
    .acq_sel    (acq_sel),
    .flag       (irq_o),
    .result     (res_val)
  );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk
  import sar_adc_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              done,
  input logic              en,
  input logic              irq,
  input logic [RES_W-1:0]  result
);
  logic go_write, clr_write;
  assign go_write  = wr_en && (wr_addr == ADDR_CTRL) && wr_data[0] && wr_data[1];
  assign clr_write = wr_en && (wr_addr == ADDR_FLAG) && !wr_data[0];

  assert_idle_without_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go_write) |=> !busy);

  assert_busy_implies_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en);

  assert_done_clears_busy_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && irq));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_write) |=> irq);

  assert_result_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result));

  assert_set_beats_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (done && clr_write) |=> irq);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_W(RES_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .busy    (seq_busy),
  .done    (seq_done),
  .en      (ctrl_en),
  .irq     (irq_o),
  .result  (res_val)
);

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic       comp_hi;
  logic [9:0] dac_code;
  logic       sample;
  logic [3:0] chan;
  logic       irq;
  logic [9:0] target;

  int n_vec = 0;
  int n_bad = 0;

  sar_adc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .comp_hi_i(comp_hi), .dac_code_o(dac_code),
    .sample_o(sample), .chan_o(chan), .irq_o(irq)
  );

  assign comp_hi = (target >= dac_code);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  function automatic int acq_len(input int s);
    case (s)
      0: return 0;  1: return 2;  2: return 4;  3: return 6;
      4: return 8;  5: return 12; 6: return 16; default: return 20;
    endcase
  endfunction

  function automatic int ratio(input int s);
    return 2 << ((s > 5) ? 5 : s);
  endfunction

  task automatic check_result(input string req, input int exp);
    int v;
    rd(3'd2, v); check(req, v, exp >> 8);
    rd(3'd3, v); check(req, v, exp & 255);
  endtask

  // full conversion: start, count cycles to completion, check everything
  task automatic run_conv(input int a, input int d, input int tgt, input int ch);
    int v, m, total;
    target = 10'(tgt);
    total = (acq_len(a) + 10) * ratio(d);
    wr(3'd1, 8'((a << 3) | d));
    wr(3'd0, 8'((ch << 2) | 3));
    rd(3'd0, v);
    check("R2 busy after start", (v >> 1) & 1, 1);
    check("R2 channel out", int'(chan), ch);
    m = 0;
    do begin
      @(negedge clk);
      m++;
      rd(3'd0, v);
      if (m == 1) check("R5 sample during acquisition", int'(sample), (acq_len(a) > 0) ? 1 : 0);
    end while (((v >> 1) & 1) == 1 && m < 5000);
    check("R7 R6 R5 latency", m, total);
    check("R9 flag with busy clear", int'(irq), 1);
    check_result("R4 R8 result", tgt);
    wr(3'd4, 8'h00);
    check("R10 flag cleared", int'(irq), 0);
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int v, prev;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; target = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd1, v); check("R1 timing", v, 0);
    rd(3'd4, v); check("R1 flag", v, 0);
    check("R1 irq", int'(irq), 0);
    check("R1 sample", int'(sample), 0);
    check("R1 dac", int'(dac_code), 0);

    // R3 start ignored while disabled
    wr(3'd0, 8'h02);
    repeat (40) @(negedge clk);
    rd(3'd0, v); check("R3 busy stays 0", (v >> 1) & 1, 0);
    check("R3 no flag", int'(irq), 0);

    // R5 R6 R7: sweep every acquisition and clock code
    for (int a = 0; a < 8; a++)
      for (int d = 0; d < 8; d++)
        run_conv(a, d, (a * 131 + d * 37 + 5) % 1024, (a + d) % 16);

    // R4 R8: every target code at the fastest setting
    for (int t = 0; t < 1024; t++)
      run_conv(0, 0, t, t % 16);

    // R10 flag sticky, write of 1 ignored
    run_conv(0, 0, 700, 1);
    target = 10'd321;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h03);
    repeat (25) @(negedge clk);
    check("R10 flag set", int'(irq), 1);
    wr(3'd4, 8'h01);
    repeat (30) @(negedge clk);
    check("R10 flag kept after writing 1", int'(irq), 1);
    wr(3'd4, 8'h00);
    check("R10 flag cleared by 0", int'(irq), 0);
    prev = 321;

    // R11 abort during acquisition
    target = 10'd999;
    wr(3'd1, 8'((3 << 3) | 1));
    wr(3'd0, 8'h03);
    repeat (5) @(negedge clk);
    check("R11 in acquisition", int'(sample), 1);
    wr(3'd0, 8'h01);
    repeat (200) @(negedge clk);
    rd(3'd0, v); check("R11 busy cleared", (v >> 1) & 1, 0);
    check("R11 flag untouched", int'(irq), 0);
    check_result("R11 result kept", prev);

    // R11 abort during conversion via enable clear
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h03);
    repeat (30) @(negedge clk);
    wr(3'd0, 8'h00);
    repeat (100) @(negedge clk);
    rd(3'd0, v); check("R11 disabled abort", (v >> 1) & 1, 0);
    check("R11 flag untouched conv", int'(irq), 0);
    check_result("R11 result kept conv", prev);

    // R12 reset mid-conversion
    wr(3'd1, 8'h09);
    wr(3'd0, 8'h17);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R12 ctrl cleared", v, 0);
    rd(3'd1, v); check("R12 timing cleared", v, 0);
    check("R12 irq", int'(irq), 0);
    check("R12 chan", int'(chan), 0);
    repeat (300) @(negedge clk);
    check("R12 no completion", int'(irq), 0);
    check_result("R12 result kept", prev);

    // R13 completion coincides with flag clear (20-cycle conversion)
    target = 10'd555;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h03);
    repeat (19) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    check("R13 set beats clear", int'(irq), 1);
    rd(3'd0, v); check("R13 busy clear", (v >> 1) & 1, 0);
    check_result("R13 result", 555);
    wr(3'd4, 8'h00);

    // R13 completion coincides with abort write
    target = 10'd88;
    wr(3'd0, 8'h03);
    repeat (19) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    check("R13 completion beats abort", int'(irq), 1);
    check_result("R13 abort-edge result", 88);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule